// File: doc/BRIEF.md
# Multi-Channel Inter-Processor Mailbox

This peripheral lets several processor sources pass short command messages to one another through a set of independent channels. Each source is known by a one-hot bit. A sender takes a free channel by writing its bit to the channel's owner register and reading the value back. It then picks the destination sources, fills the data words and writes its bit to the send register. Unmasked destinations then see a level interrupt until they clear it.

A channel in auto-answer mode moves straight to an acknowledged state after a send. It also raises the owner's own interrupt. The owner clears that acknowledge and then writes its bit to the owner register again, which frees the channel. A key register guards every channel write: only one magic value opens it, and any other value written to it closes it again. Reads are never blocked by the key.

The register bus is a plain 32-bit single-cycle port. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every channel's mode register reads 0x10 and its owner register reads 0. The key register at 0xA00 reads 1 (locked), and all interrupt outputs are low.
- R2: Writing 0x1ACCE551 to 0xA00 unlocks, and 0xA00 then reads 0. Any other value written there locks again. While locked, every channel write is dropped, but reads return the current values.
- R3: Channel m uses the 64-byte window at m*0x40. When the channel is idle, a write to its owner register (offset 0x00) of a value with exactly one bit set among the low 6 bits (all other bits zero) makes that value the owner. The mode register (0x10) then reads 0x20. A write of any other value leaves the channel idle.
- R4: While a channel is owned, an owner-register write of any value other than the owner's bit leaves the owner unchanged.
- R5: When the owner writes its own bit to the owner register, the channel is released. Mode reads 0x10, the owner reads 0, and the destination status, mask, pending events, acknowledge and auto-answer mode are all cleared.
- R6: On an owned channel, a write to 0x04 ORs the value into the destination status and a write to 0x08 clears the written bits. Offset 0x0C reads the status.
- R7: On an owned channel, data word i sits at 0x20+4*i and reads back what was written.
- R8: A send (0x1C) of the owner's bit while the channel is in the owned state copies the destination status into the pending events. Mode then reads 0x40 in normal mode.
- R9: Writing 1 to bit 0 of mode in the owned state selects auto-answer, and mode then reads 0x21. A send then makes mode read 0x81 and raises the acknowledge on the owner's interrupt. Mode writes in any other state are ignored.
- R10: A set bit in the 6-bit mask (0x14) suppresses that source's interrupt without discarding its pending event.
- R11: A write to the interrupt-clear register (0x18) clears the written pending bits. When the owner's bit is written in the acknowledged state, the acknowledge is dropped and mode returns to 0x21.
- R12: A send from a non-owner, or from any state other than owned, has no effect.
- R13: The interrupt for source s is the OR over all channels of that channel's unmasked pending or acknowledge events for s. Undecoded addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| src_irq | output | 6 | Level interrupt for each source |

## Verification
Owner-register writes are tried with a value that is not one-hot, a foreign bit, and the owner's own bit. This separates a failed claim, a protected owner and a release. Sends are issued by a non-owner, by the owner in the owned state, and again in the sent state, so an ignored send can be told apart from a real one. Destinations are spread over two channels that target the same source, which shows the interrupt is an OR across channels and not the latest channel alone. Mask and clear patterns are chosen so that a masked bit which is still pending reappears when the mask is removed.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_OWNED = 2'd1,
      ST_SENT  = 2'd2,
      ST_ACKED = 2'd3
   } chan_st_e;

   localparam logic [5:0] OFF_SRC  = 6'h00;
   localparam logic [5:0] OFF_DSET = 6'h04;
   localparam logic [5:0] OFF_DCLR = 6'h08;
   localparam logic [5:0] OFF_DSTA = 6'h0C;
   localparam logic [5:0] OFF_MODE = 6'h10;
   localparam logic [5:0] OFF_MASK = 6'h14;
   localparam logic [5:0] OFF_ICLR = 6'h18;
   localparam logic [5:0] OFF_SEND = 6'h1C;

   localparam logic [31:0] KEY_VALUE = 32'h1ACC_E551;

   function automatic logic [3:0] st_code(chan_st_e st);
      case (st)
         ST_IDLE:  return 4'h1;
         ST_OWNED: return 4'h2;
         ST_SENT:  return 4'h4;
         default:  return 4'h8;
      endcase
   endfunction
endpackage

// File: rtl/mbx_key.sv
module mbx_key
   import mbx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [WORD_W-1:0] key_data,
   output logic              unlocked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      unlocked <= 1'b0;
      else if (key_wr) unlocked <= (key_data == KEY_VALUE);
   end

   // R2
   relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_data != KEY_VALUE) |=> !unlocked);

   // R2
   unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_data == KEY_VALUE) |=> unlocked);
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan
   import mbx_pkg::*;
#(
   parameter int unsigned NSRC  = 6,
   parameter int unsigned NDATA = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [5:0]        off,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output logic [NSRC-1:0]   irq_vec
);
   chan_st_e          st_q;
   logic [NSRC-1:0]   owner_q, dsta_q, mask_q, pend_q;
   logic              auto_q;
   logic [WORD_W-1:0] data_q [NDATA];

   wire [NSRC-1:0] wsrc     = wdata[NSRC-1:0];
   wire            hi_zero  = (wdata >> NSRC) == '0;
   wire            src_one  = hi_zero && $onehot(wsrc);
   wire            is_owner = hi_zero && (st_q != ST_IDLE) && (wsrc == owner_q);
   wire            held_wr  = wr_en && (st_q != ST_IDLE);
   wire            dat_hit  = off[5] && (off[1:0] == 2'b00);
   wire [2:0]      dat_idx  = off[4:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         owner_q <= '0;
         dsta_q  <= '0;
         mask_q  <= '0;
         pend_q  <= '0;
         auto_q  <= 1'b0;
      end else if (wr_en && off == OFF_SRC) begin
         if (st_q == ST_IDLE) begin
            if (src_one) begin
               owner_q <= wsrc;
               st_q    <= ST_OWNED;
            end
         end else if (is_owner) begin
            st_q    <= ST_IDLE;
            owner_q <= '0;
            dsta_q  <= '0;
            mask_q  <= '0;
            pend_q  <= '0;
            auto_q  <= 1'b0;
         end
      end else if (held_wr) begin
         case (off)
            OFF_DSET: dsta_q <= dsta_q | wsrc;
            OFF_DCLR: dsta_q <= dsta_q & ~wsrc;
            OFF_MASK: mask_q <= wsrc;
            OFF_MODE: if (st_q == ST_OWNED) auto_q <= wdata[0];
            OFF_ICLR: begin
               pend_q <= pend_q & ~wsrc;
               if (st_q == ST_ACKED && is_owner) st_q <= ST_OWNED;
            end
            OFF_SEND: if (st_q == ST_OWNED && is_owner) begin
               pend_q <= dsta_q;
               st_q   <= auto_q ? ST_ACKED : ST_SENT;
            end
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < NDATA; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) data_q[g] <= '0;
         else if (held_wr && dat_hit && dat_idx == 3'(g)) data_q[g] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      case (off)
         OFF_SRC:  rdata[NSRC-1:0] = owner_q;
         OFF_DSTA: rdata[NSRC-1:0] = dsta_q;
         OFF_MODE: rdata[7:0]      = {st_code(st_q), 3'b000, auto_q};
         OFF_MASK: rdata[NSRC-1:0] = mask_q;
         default:  ;
      endcase
      for (int i = 0; i < NDATA; i++)
         if (dat_hit && dat_idx == 3'(i)) rdata = data_q[i];
   end

   assign irq_vec = (pend_q | ((st_q == ST_ACKED) ? owner_q : '0)) & ~mask_q;

   // R3
   owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owner_q));

   // R4
   owner_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> (st_q == ST_IDLE || $stable(owner_q)));

   // R12
   send_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |=> (st_q != ST_SENT && st_q != ST_ACKED));

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> (irq_vec == '0 && owner_q == '0));
endmodule

// File: rtl/mbx_irq_or.sv
module mbx_irq_or #(
   parameter int unsigned NCH  = 8,
   parameter int unsigned NSRC = 6
) (
   input  logic [NCH*NSRC-1:0] chan_irq,
   output logic [NSRC-1:0]     src_irq
);
   for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic [NCH-1:0] col;
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         assign col[c] = chan_irq[c*NSRC + s];
      end
      assign src_irq[s] = |col;
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned NCH   = 8,
   parameter int unsigned NDATA = 2,
   parameter int unsigned NSRC  = 6,
   parameter int unsigned AW    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic [NSRC-1:0]   src_irq
);
   localparam int unsigned     CHW      = (NCH > 1) ? $clog2(NCH) : 1;
   localparam logic [AW-1:0]   KEY_ADDR = AW'(12'hA00);

   if (NDATA < 1 || NDATA > 8) begin : g_bad_ndata
      $error("NDATA must lie in 1..8");
   end
   if (NSRC < 1 || NSRC > 31) begin : g_bad_nsrc
      $error("NSRC must lie in 1..31");
   end
   if (NCH * 64 > 12'hA00 || AW < 12) begin : g_bad_map
      $error("channel windows overlap the key register");
   end

   logic                     unlocked;
   logic [WORD_W-1:0]        ch_rdata [NCH];
   logic [NCH*NSRC-1:0]      ch_irq;

   wire            key_hit = (bus_addr == KEY_ADDR);
   wire [AW-7:0]   win     = bus_addr[AW-1:6];
   wire            ch_hit  = 32'(win) < NCH;

   mbx_key u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (bus_sel && bus_wr && key_hit),
      .key_data (bus_wdata),
      .unlocked (unlocked)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      mbx_chan #(.NSRC(NSRC), .NDATA(NDATA)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bus_sel && bus_wr && unlocked && ch_hit && 32'(win) == c),
         .off     (bus_addr[5:0]),
         .wdata   (bus_wdata),
         .rdata   (ch_rdata[c]),
         .irq_vec (ch_irq[c*NSRC +: NSRC])
      );
   end

   mbx_irq_or #(.NCH(NCH), .NSRC(NSRC)) u_irq (
      .chan_irq (ch_irq),
      .src_irq  (src_irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (key_hit) bus_rdata = {31'b0, !unlocked};
      for (int c = 0; c < NCH; c++)
         if (ch_hit && 32'(win) == c) bus_rdata = ch_rdata[c];
   end
endmodule

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/100ps
module ipc_mailbox_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  src_irq;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   ipc_mailbox u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_irq(src_irq)
   );

   localparam logic [11:0] KEY = 12'hA00;
   function automatic logic [11:0] ra(int ch, int off);
      return 12'(ch * 64 + off);
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 check(tag, bus_rdata, exp);
      bus_sel = 0;
   endtask

   task automatic irq_chk(string tag, logic [5:0] exp);
      @(negedge clk);
      #1 check(tag, 32'(src_irq), 32'(exp));
   endtask

   task automatic t_reset;
      rd_chk("R1 ch0 mode", ra(0, 'h10), 32'h10);
      rd_chk("R1 ch7 mode", ra(7, 'h10), 32'h10);
      rd_chk("R1 ch0 owner", ra(0, 0), 0);
      rd_chk("R1 key locked", KEY, 1);
      irq_chk("R1 irq idle", 0);
   endtask

   task automatic t_key;
      wr(ra(0, 0), 1);
      rd_chk("R2 locked write dropped", ra(0, 0), 0);
      wr(KEY, 32'h1ACCE551);
      rd_chk("R2 unlocked", KEY, 0);
      wr(KEY, 32'h0);
      rd_chk("R2 relocked", KEY, 1);
      wr(KEY, 32'h1ACCE551);
   endtask

   task automatic t_claim;
      wr(ra(0, 0), 3);
      rd_chk("R3 non-onehot claim", ra(0, 0), 0);
      wr(ra(0, 0), 1);
      rd_chk("R3 owner", ra(0, 0), 1);
      rd_chk("R3 mode owned", ra(0, 'h10), 32'h20);
      wr(ra(0, 0), 2);
      rd_chk("R4 foreign owner write", ra(0, 0), 1);
   endtask

   task automatic t_dest_data;
      wr(ra(0, 4), 6);
      rd_chk("R6 dest set", ra(0, 'hC), 6);
      wr(ra(0, 4), 8);
      rd_chk("R6 dest or", ra(0, 'hC), 32'hE);
      wr(ra(0, 8), 4);
      rd_chk("R6 dest clear", ra(0, 'hC), 32'hA);
      wr(ra(0, 'h20), 32'hDEADBEEF);
      wr(ra(0, 'h24), 32'h12345678);
      rd_chk("R7 data0", ra(0, 'h20), 32'hDEADBEEF);
      rd_chk("R7 data1", ra(0, 'h24), 32'h12345678);
   endtask

   task automatic t_send;
      wr(ra(0, 'h1C), 2);
      rd_chk("R12 non-owner send mode", ra(0, 'h10), 32'h20);
      irq_chk("R12 non-owner send irq", 0);
      wr(ra(0, 'h1C), 1);
      rd_chk("R8 mode sent", ra(0, 'h10), 32'h40);
      irq_chk("R8 irq dest", 6'h0A);
      wr(ra(0, 'h14), 8);
      irq_chk("R10 masked", 6'h02);
      wr(ra(0, 4), 32'h1);
      wr(ra(0, 'h1C), 1);
      irq_chk("R12 resend in sent state", 6'h02);
      wr(ra(0, 'h18), 2);
      irq_chk("R11 pending cleared", 0);
      wr(ra(0, 'h14), 0);
      irq_chk("R10 masked pending kept", 6'h08);
      wr(ra(0, 0), 1);
      rd_chk("R5 mode idle", ra(0, 'h10), 32'h10);
      rd_chk("R5 owner clear", ra(0, 0), 0);
      rd_chk("R5 dest clear", ra(0, 'hC), 0);
      irq_chk("R5 irq clear", 0);
   endtask

   task automatic t_auto;
      wr(ra(2, 'h10), 1);
      rd_chk("R9 idle mode write ignored", ra(2, 'h10), 32'h10);
      wr(ra(3, 0), 4);
      wr(ra(3, 'h10), 1);
      rd_chk("R9 auto mode", ra(3, 'h10), 32'h21);
      wr(ra(3, 'h14), 32'h33);
      wr(ra(3, 4), 8);
      wr(ra(3, 'h1C), 4);
      rd_chk("R9 acked", ra(3, 'h10), 32'h81);
      irq_chk("R9 ack irq", 6'h0C);
      wr(ra(3, 'h18), 8);
      irq_chk("R11 dest cleared ack kept", 6'h04);
      rd_chk("R11 still acked", ra(3, 'h10), 32'h81);
      wr(ra(3, 'h18), 4);
      rd_chk("R11 ack cleared", ra(3, 'h10), 32'h21);
      irq_chk("R11 irq after ack clear", 0);
      wr(ra(3, 0), 4);
      rd_chk("R5 auto cleared", ra(3, 'h10), 32'h10);
   endtask

   task automatic t_multi;
      wr(ra(1, 0), 1);
      wr(ra(1, 4), 32'h10);
      wr(ra(1, 'h1C), 1);
      wr(ra(6, 0), 2);
      wr(ra(6, 4), 32'h10);
      wr(ra(6, 'h1C), 2);
      irq_chk("R13 two channels", 6'h10);
      wr(ra(1, 'h18), 32'h10);
      irq_chk("R13 other channel holds", 6'h10);
      wr(ra(6, 'h18), 32'h10);
      irq_chk("R13 all cleared", 0);
   endtask

   task automatic t_misc;
      rd_chk("R13 undecoded key+4", 12'hA04, 0);
      rd_chk("R13 dset reads zero", ra(1, 4), 0);
      rd_chk("R13 beyond channels", 12'h200, 0);
      rd_chk("R13 data index 2", ra(1, 'h28), 0);
      wr(KEY, 32'h5);
      rd_chk("R2 read while locked", ra(1, 0), 1);
      wr(ra(1, 0), 1);
      rd_chk("R2 release dropped", ra(1, 0), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_key();
      t_claim();
      t_dest_data();
      t_send();
      t_auto();
      t_multi();
      t_misc();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule